// File: doc/BRIEF.md
# Four-Channel PWM Register Block

This block puts four pulse-width channels behind one 32-bit word-addressed register port. Software starts channels through a write-one-to-set register and stops them through a separate write-one-to-clear register, so one write never disturbs the other channels. A status register shows which channels are running. A sticky event register collects one flag per channel each time that channel finishes a period, and reading it clears it.

Each channel has its own register window. The window holds a mode word (clock prescaler, output polarity and an update-target bit), direct duty and period registers that take effect at once, and two staged update registers. A staged value is loaded into the live duty or period only at the channel's next period boundary. A single interrupt line is the OR of the pending event flags.

A channel counts from 0 to period-1. It advances one step every 2^prescale clocks. Its output is active while the count is below the duty value. While a channel is stopped, its counter is held at zero and its output sits at the inactive level.

Top module: `pwm_regs_top`

## Requirements
- R1: After reset every register reads zero, no channel runs, all outputs are 0 and the interrupt is low.
- R2: A write to offset 0x04 starts channel n for each 1 in data bit n. Zero bits leave the channel as it was. Status at 0x0C bit n reads 1 while channel n runs.
- R3: A write to offset 0x08 stops channel n for each 1 in data bit n. A stopped channel's output returns to its inactive level on the next clock.
- R4: A read of offset 0x1C returns the event flags and clears them. An event raised in the same cycle as that read is set after the read.
- R5: Channel n's window starts at 0x200 + 0x20*n. The mode word at window offset 0x00 keeps the prescaler in bits 3:0, the polarity in bit 9 and the update-target bit in bit 10. All other bits read 0.
- R6: Duty at window offset 0x04 and period at 0x0C are 16 bits wide and take effect from the next clock. Upper data bits are dropped.
- R7: Staged duty at window offset 0x08 and staged period at 0x10 read back as written. They are copied into the live duty or period only at the channel's next period end.
- R8: A running channel counts 0..period-1 and advances once every 2^prescale clocks. Its output is (count < duty) XOR polarity. A stopped channel outputs its polarity bit.
- R9: Event flag n is set at every period end of running channel n and stays set until the event register is read.
- R10: Reads of unaligned or unmapped addresses return 0. Writes to them, and writes to the status or event offsets, change nothing.
- R11: Read data appears on the clock edge that samples the read enable and holds until the next read.
- R12: The interrupt output is high while any event flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Byte address |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 32 | Write data |
| busRdEn | input | 1 | Read strobe |
| busRdData | output | 32 | Registered read data |
| pwmOut | output | 4 | Channel waveforms |
| irq | output | 1 | OR of pending event flags |

## Verification
The assertions assume a single bus address per cycle, so a start and a stop never reach the same channel in one cycle. They also assume the bus strobes are low while reset is held. The stimulus only issues one read or one write per cycle, always at a negative edge, and keeps every strobe at zero during reset. The bench holds the event-register read enable high across many consecutive cycles while a short-period channel runs. This forces a clear and a new event to coincide repeatedly.

// File: rtl/pwm_regs_pkg.sv
package pwm_regs_pkg;
  parameter int NUM_CH     = 4;
  parameter int CNT_W      = 16;
  parameter int PRE_W      = 4;
  parameter int ADDR_W     = 12;
  parameter int DATA_W     = 32;
  parameter int STRIDE_LG2 = 5;
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int PS_W      = (1 << PRE_W) - 1;

  localparam logic [ADDR_W-1:0] ADR_START = 12'h004;
  localparam logic [ADDR_W-1:0] ADR_STOP  = 12'h008;
  localparam logic [ADDR_W-1:0] ADR_STAT  = 12'h00C;
  localparam logic [ADDR_W-1:0] ADR_EVT   = 12'h01C;
  localparam logic [ADDR_W-1:0] WIN_BASE  = 12'h200;
  localparam logic [ADDR_W-1:0] WIN_END   = ADDR_W'(32'h200 + NUM_CH * (1 << STRIDE_LG2));

  localparam logic [STRIDE_LG2-1:0] WOFF_MODE  = 5'h00;
  localparam logic [STRIDE_LG2-1:0] WOFF_DUTY  = 5'h04;
  localparam logic [STRIDE_LG2-1:0] WOFF_DSTG  = 5'h08;
  localparam logic [STRIDE_LG2-1:0] WOFF_PRD   = 5'h0C;
  localparam logic [STRIDE_LG2-1:0] WOFF_PSTG  = 5'h10;

  localparam int MODE_POL_BIT = 9;
  localparam int MODE_TGT_BIT = 10;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_EVT, SEL_MODE, SEL_DUTY, SEL_DSTG, SEL_PRD, SEL_PSTG
  } regSel_e;

  typedef struct packed {
    logic            wrStart;
    logic            wrStop;
    logic            wrCh;
    logic            rd;
    logic            rdEvt;
    regSel_e         sel;
    logic [CH_W-1:0] ch;
  } busStrb_t;
endpackage

// File: rtl/pwm_chan_core.sv
module pwm_chan_core
  import pwm_regs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic [PRE_W-1:0] preSel,
  input  logic             polInv,
  input  logic [CNT_W-1:0] dutyVal,
  input  logic [CNT_W-1:0] prdVal,
  output logic             wave,
  output logic             periodEnd
);
  logic [PS_W-1:0]  psCnt;
  logic [PS_W-1:0]  psLim;
  logic [CNT_W-1:0] cnt;
  logic             tick;
  logic             atLast;

  assign psLim     = ~({PS_W{1'b1}} << preSel);
  assign tick      = run && (psCnt == psLim);
  assign atLast    = ({1'b0, cnt} + (CNT_W+1)'(1)) >= {1'b0, prdVal};
  assign periodEnd = tick && atLast;
  assign wave      = (run && (cnt < dutyVal)) ^ polInv;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      psCnt <= '0;
      cnt   <= '0;
    end else if (!run) begin
      psCnt <= '0;
      cnt   <= '0;
    end else if (tick) begin
      psCnt <= '0;
      cnt   <= atLast ? '0 : cnt + CNT_W'(1);
    end else begin
      psCnt <= psCnt + PS_W'(1);
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    periodEnd |=> (cnt == '0)) else $error("wrap"); // R8
endmodule

// File: rtl/pwm_reg_ctrl.sv
module pwm_reg_ctrl
  import pwm_regs_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output busStrb_t          strb
);
  logic [ADDR_W-1:0] winOff;
  logic              inWin;
  logic              isStart;
  logic              isStop;
  regSel_e           sel;

  always_comb begin
    winOff  = addr - WIN_BASE;
    inWin   = (addr >= WIN_BASE) && (addr < WIN_END);
    isStart = 1'b0;
    isStop  = 1'b0;
    sel     = SEL_NONE;
    strb    = '0;
    if (addr[1:0] == 2'b00) begin
      if (addr == ADR_START)     isStart = 1'b1;
      else if (addr == ADR_STOP) isStop  = 1'b1;
      else if (addr == ADR_STAT) sel     = SEL_STAT;
      else if (addr == ADR_EVT)  sel     = SEL_EVT;
      else if (inWin) begin
        strb.ch = winOff[STRIDE_LG2 +: CH_W];
        case (winOff[STRIDE_LG2-1:0])
          WOFF_MODE: sel = SEL_MODE;
          WOFF_DUTY: sel = SEL_DUTY;
          WOFF_DSTG: sel = SEL_DSTG;
          WOFF_PRD:  sel = SEL_PRD;
          WOFF_PSTG: sel = SEL_PSTG;
          default:   sel = SEL_NONE;
        endcase
      end
    end
    strb.sel     = sel;
    strb.wrStart = wrEn && isStart;
    strb.wrStop  = wrEn && isStop;
    strb.wrCh    = wrEn && (sel inside {SEL_MODE, SEL_DUTY, SEL_DSTG, SEL_PRD, SEL_PSTG});
    strb.rd      = rdEn;
    strb.rdEvt   = rdEn && (sel == SEL_EVT);
  end
endmodule

// File: rtl/pwm_reg_dpath.sv
module pwm_reg_dpath
  import pwm_regs_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  busStrb_t                      strb,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_CH-1:0]             chEnd,
  output logic [NUM_CH-1:0]             runQ,
  output logic [NUM_CH-1:0]             evtQ,
  output logic [NUM_CH-1:0][PRE_W-1:0]  preQ,
  output logic [NUM_CH-1:0]             polQ,
  output logic [NUM_CH-1:0][CNT_W-1:0]  dutyQ,
  output logic [NUM_CH-1:0][CNT_W-1:0]  prdQ,
  output logic [DATA_W-1:0]             rdData
);
  logic [NUM_CH-1:0]            tgtQ;
  logic [NUM_CH-1:0][CNT_W-1:0] dStgQ;
  logic [NUM_CH-1:0][CNT_W-1:0] pStgQ;
  logic [NUM_CH-1:0]            dStgV;
  logic [NUM_CH-1:0]            pStgV;
  logic [NUM_CH-1:0]            setMask;
  logic [NUM_CH-1:0]            clrMask;
  logic [DATA_W-1:0]            rdNext;

  assign setMask = strb.wrStart ? wrData[NUM_CH-1:0] : '0;
  assign clrMask = strb.wrStop  ? wrData[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= '0;
      evtQ <= '0;
    end else begin
      runQ <= (runQ | setMask) & ~clrMask;
      evtQ <= (strb.rdEvt ? '0 : evtQ) | chEnd;
    end
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chRegs
    logic hit;
    assign hit = strb.wrCh && (strb.ch == CH_W'(g));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        preQ[g] <= '0; polQ[g] <= 1'b0; tgtQ[g] <= 1'b0;
        dutyQ[g] <= '0; prdQ[g] <= '0;
        dStgQ[g] <= '0; pStgQ[g] <= '0;
        dStgV[g] <= 1'b0; pStgV[g] <= 1'b0;
      end else begin
        if (chEnd[g] && dStgV[g]) begin
          dutyQ[g] <= dStgQ[g];
          dStgV[g] <= 1'b0;
        end
        if (chEnd[g] && pStgV[g]) begin
          prdQ[g]  <= pStgQ[g];
          pStgV[g] <= 1'b0;
        end
        if (hit) begin
          case (strb.sel)
            SEL_MODE: begin
              preQ[g] <= wrData[PRE_W-1:0];
              polQ[g] <= wrData[MODE_POL_BIT];
              tgtQ[g] <= wrData[MODE_TGT_BIT];
            end
            SEL_DUTY: dutyQ[g] <= wrData[CNT_W-1:0];
            SEL_DSTG: begin dStgQ[g] <= wrData[CNT_W-1:0]; dStgV[g] <= 1'b1; end
            SEL_PRD:  prdQ[g] <= wrData[CNT_W-1:0];
            SEL_PSTG: begin pStgQ[g] <= wrData[CNT_W-1:0]; pStgV[g] <= 1'b1; end
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rdNext = '0;
    case (strb.sel)
      SEL_STAT: rdNext[NUM_CH-1:0] = runQ;
      SEL_EVT:  rdNext[NUM_CH-1:0] = evtQ;
      SEL_MODE: begin
        rdNext[PRE_W-1:0]     = preQ[strb.ch];
        rdNext[MODE_POL_BIT]  = polQ[strb.ch];
        rdNext[MODE_TGT_BIT]  = tgtQ[strb.ch];
      end
      SEL_DUTY: rdNext[CNT_W-1:0] = dutyQ[strb.ch];
      SEL_DSTG: rdNext[CNT_W-1:0] = dStgQ[strb.ch];
      SEL_PRD:  rdNext[CNT_W-1:0] = prdQ[strb.ch];
      SEL_PSTG: rdNext[CNT_W-1:0] = pStgQ[strb.ch];
      default:  rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        rdData <= '0;
    else if (strb.rd) rdData <= rdNext;
  end

  AST_START_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStart |=> ((runQ & $past(wrData[NUM_CH-1:0])) == $past(wrData[NUM_CH-1:0]))) else $error("start"); // R2
  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrStop |=> ((runQ & $past(wrData[NUM_CH-1:0])) == '0)) else $error("stop"); // R3
  AST_EVT_READ_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdEvt |=> (evtQ == $past(chEnd))) else $error("evt clear"); // R4
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdEvt |=> ((evtQ & $past(evtQ)) == $past(evtQ))) else $error("evt sticky"); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && strb.sel == SEL_NONE) |=> (rdData == '0)) else $error("unmapped"); // R10
endmodule

// File: rtl/pwm_regs_top.sv
module pwm_regs_top
  import pwm_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  input  logic              busRdEn,
  output logic [DATA_W-1:0] busRdData,
  output logic [NUM_CH-1:0] pwmOut,
  output logic              irq
);
  busStrb_t                     strb;
  logic [NUM_CH-1:0]            chEnd;
  logic [NUM_CH-1:0]            runQ;
  logic [NUM_CH-1:0]            evtQ;
  logic [NUM_CH-1:0][PRE_W-1:0] preQ;
  logic [NUM_CH-1:0]            polQ;
  logic [NUM_CH-1:0][CNT_W-1:0] dutyQ;
  logic [NUM_CH-1:0][CNT_W-1:0] prdQ;

  pwm_reg_ctrl ctrl_i (
    .addr (busAddr),
    .wrEn (busWrEn),
    .rdEn (busRdEn),
    .strb (strb)
  );

  pwm_reg_dpath dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (busWrData),
    .chEnd  (chEnd),
    .runQ   (runQ),
    .evtQ   (evtQ),
    .preQ   (preQ),
    .polQ   (polQ),
    .dutyQ  (dutyQ),
    .prdQ   (prdQ),
    .rdData (busRdData)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_core
    pwm_chan_core core_i (
      .clk       (clk),
      .rstN      (rstN),
      .run       (runQ[g]),
      .preSel    (preQ[g]),
      .polInv    (polQ[g]),
      .dutyVal   (dutyQ[g]),
      .prdVal    (prdQ[g]),
      .wave      (pwmOut[g]),
      .periodEnd (chEnd[g])
    );
  end

  assign irq = |evtQ;
endmodule

// File: tb/pwm_regs_top_tb_top.sv
`timescale 1ns/1ps
module pwm_regs_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] bAddr = '0;
  logic        bWrEn = 1'b0;
  logic [31:0] bWd = '0;
  logic        bRdEn = 1'b0;
  logic [31:0] bRd;
  logic [3:0]  pwmOut;
  logic        irq;

  int checks = 0;
  int errs = 0;
  string curReq = "R11";

  // behavioural model state
  int mRun[4], mEvt[4], mPre[4], mPol[4], mTgt[4];
  int mDuty[4], mPrd[4], mDStg[4], mPStg[4], mDV[4], mPV[4];
  int mCnt[4], mPs[4], mEnd[4];
  int mRd = 0;
  bit mRdPend = 0;

  always #4 clk = ~clk;

  pwm_regs_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(bAddr), .busWrEn(bWrEn), .busWrData(bWd),
    .busRdEn(bRdEn), .busRdData(bRd), .pwmOut(pwmOut), .irq(irq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int mRead(input int a);
    int ch, off;
    if (a % 4 != 0) return 0;
    if (a == 'h0C) return mRun[0] | mRun[1] << 1 | mRun[2] << 2 | mRun[3] << 3;
    if (a == 'h1C) return mEvt[0] | mEvt[1] << 1 | mEvt[2] << 2 | mEvt[3] << 3;
    if (a < 'h200 || a >= 'h280) return 0;
    ch = (a - 'h200) / 32;
    off = (a - 'h200) % 32;
    case (off)
      0:  return mPre[ch] | (mPol[ch] << 9) | (mTgt[ch] << 10);
      4:  return mDuty[ch];
      8:  return mDStg[ch];
      12: return mPrd[ch];
      16: return mPStg[ch];
      default: return 0;
    endcase
  endfunction

  function automatic int mWave();
    int w = 0;
    for (int c = 0; c < 4; c++)
      w |= (((mRun[c] != 0 && mCnt[c] < mDuty[c]) ? 1 : 0) ^ mPol[c]) << c;
    return w;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int c = 0; c < 4; c++) begin
        mRun[c] = 0; mEvt[c] = 0; mPre[c] = 0; mPol[c] = 0; mTgt[c] = 0;
        mDuty[c] = 0; mPrd[c] = 0; mDStg[c] = 0; mPStg[c] = 0; mDV[c] = 0; mPV[c] = 0;
        mCnt[c] = 0; mPs[c] = 0;
      end
      mRd = 0; mRdPend = 0;
    end else begin
      int a, d, ch, off;
      a = int'(bAddr); d = int'(bWd);
      for (int c = 0; c < 4; c++) begin
        bit tk;
        tk = mRun[c] != 0 && mPs[c] == (1 << mPre[c]) - 1;
        mEnd[c] = (tk && mCnt[c] + 1 >= mPrd[c]) ? 1 : 0;
        if (mRun[c] == 0) begin mCnt[c] = 0; mPs[c] = 0; end
        else if (tk) begin mPs[c] = 0; mCnt[c] = mEnd[c] ? 0 : mCnt[c] + 1; end
        else mPs[c]++;
      end
      mRdPend = bRdEn;
      if (bRdEn) begin
        mRd = mRead(a);
        if (a == 'h1C) for (int c = 0; c < 4; c++) mEvt[c] = 0;
      end
      for (int c = 0; c < 4; c++) begin
        if (mEnd[c] != 0) mEvt[c] = 1;
        if (mEnd[c] != 0 && mDV[c] != 0) begin mDuty[c] = mDStg[c]; mDV[c] = 0; end
        if (mEnd[c] != 0 && mPV[c] != 0) begin mPrd[c] = mPStg[c]; mPV[c] = 0; end
      end
      if (bWrEn) begin
        if (a == 'h04) for (int c = 0; c < 4; c++) if (d[c]) mRun[c] = 1;
        if (a == 'h08) for (int c = 0; c < 4; c++) if (d[c]) mRun[c] = 0;
        if (a % 4 == 0 && a >= 'h200 && a < 'h280) begin
          ch = (a - 'h200) / 32; off = (a - 'h200) % 32;
          case (off)
            0:  begin mPre[ch] = d & 'hF; mPol[ch] = d[9]; mTgt[ch] = d[10]; end
            4:  mDuty[ch] = d & 'hFFFF;
            8:  begin mDStg[ch] = d & 'hFFFF; mDV[ch] = 1; end
            12: mPrd[ch] = d & 'hFFFF;
            16: begin mPStg[ch] = d & 'hFFFF; mPV[ch] = 1; end
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk("R8", pwmOut, mWave());
      chk("R12", irq, (mEvt[0] | mEvt[1] | mEvt[2] | mEvt[3]));
      if (mRdPend) chk(curReq, bRd, mRd);
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bAddr = a; bWd = d; bWrEn = 1'b1;
    @(negedge clk);
    bWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] v);
    bAddr = a; bRdEn = 1'b1;
    @(negedge clk);
    v = bRd;
    bRdEn = 1'b0;
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    chk("R1", pwmOut, 0);
    chk("R1", irq, 0);
    rstN = 1'b1;
    @(negedge clk);
    curReq = "R1";
    rd(12'h00C, v); chk("R1", v, 0);
    rd(12'h01C, v); chk("R1", v, 0);
    rd(12'h244, v); chk("R1", v, 0);

    curReq = "R5";
    wr(12'h220, 32'hFFFF_FFFF);
    rd(12'h220, v); chk("R5", v, 32'h0000_060F);
    wr(12'h220, 32'h0);

    curReq = "R6";
    wr(12'h204, 32'h1234_5678);
    rd(12'h204, v); chk("R6", v, 32'h5678);

    curReq = "R10";
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h100, v); chk("R10", v, 0);
    rd(12'h206, v); chk("R10", v, 0);
    rd(12'h280, v); chk("R10", v, 0);
    rd(12'h214, v); chk("R10", v, 0);

    curReq = "R8";
    wr(12'h204, 32'd2); wr(12'h20C, 32'd5);
    wr(12'h240, 32'h0000_0201); wr(12'h244, 32'd3); wr(12'h24C, 32'd4);
    chk("R8", pwmOut, 4'b0100);

    curReq = "R2";
    wr(12'h004, 32'h5);
    rd(12'h00C, v); chk("R2", v, 5);
    wr(12'h004, 32'h0);
    rd(12'h00C, v); chk("R2", v, 5);
    curReq = "R10";
    wr(12'h00C, 32'hF); wr(12'h01C, 32'h0);
    rd(12'h00C, v); chk("R10", v, 5);

    curReq = "R8";
    repeat (40) @(negedge clk);

    curReq = "R7";
    wr(12'h208, 32'd4);
    rd(12'h204, v); chk("R7", v, 2);
    rd(12'h208, v); chk("R7", v, 4);
    repeat (8) @(negedge clk);
    rd(12'h204, v); chk("R7", v, 4);
    wr(12'h250, 32'd6);
    rd(12'h24C, v); chk("R7", v, 4);
    repeat (20) @(negedge clk);
    rd(12'h24C, v); chk("R7", v, 6);

    curReq = "R4";
    bAddr = 12'h01C; bRdEn = 1'b1;
    repeat (14) @(negedge clk);
    bRdEn = 1'b0;
    curReq = "R3";
    wr(12'h008, 32'h1);
    chk("R3", pwmOut[0], 0);
    rd(12'h00C, v); chk("R3", v, 4);
    wr(12'h008, 32'hF);
    curReq = "R4";
    repeat (2) @(negedge clk);
    rd(12'h01C, v);
    rd(12'h01C, v); chk("R4", v, 0);
    chk("R12", irq, 0);

    curReq = "R9";
    wr(12'h004, 32'h1);
    repeat (12) @(negedge clk);
    rd(12'h01C, v); chk("R9", v[0], 1);
    wr(12'h008, 32'hF);

    curReq = "R11";
    rd(12'h00C, v); chk("R11", v, 0);
    repeat (2) @(negedge clk);
    chk("R11", bRd, 0);

    summary();
    $finish;
  end
endmodule